// File: doc/BRIEF.md
# Depth Test with Triangle Index Buffer

This block sits behind scan conversion in a raster pipeline. Each incoming pixel carries its screen coordinates, a depth and the number of the triangle that produced it. The block keeps a screen-sized buffer. Each entry of that buffer holds a depth value and a triangle number side by side. For every pixel it reads the entry at the pixel's position and compares the two depths. When the new pixel is nearer, it overwrites both fields of the entry with a single write. The buffer therefore always records which triangle owns each visible pixel.

While a triangle streams through, the block remembers whether any of its pixels won. When the beat marked last has been processed, it reports one verdict for the whole triangle: the triangle number and a visible bit. Downstream lighting uses that verdict to skip triangles that are fully hidden. A later shading pass reads the stored triangle numbers through a scan-out port. A clear sweep prepares the buffer for the next frame.

Top module: `zidx_depth_test`

## Requirements
- R1: After reset, `pix_ready` is 1 and `vis_valid` and `clr_busy` are 0.
- R2: A one-cycle `clr_go` raises `clr_busy` for exactly 2^(2·CW) cycles. During those cycles `pix_ready` is 0. Afterwards every entry reads depth all-ones and triangle number all-ones, the reserved "no triangle" value.
- R3: A pixel passes only when its depth is strictly less than the stored depth. A pass replaces the stored depth and triangle number together. A pixel whose depth is equal or greater leaves the entry unchanged.
- R4: A triangle with at least one passing pixel gets a verdict with `vis_hit` = 1.
- R5: A triangle whose pixels all fail gets a verdict with `vis_hit` = 0.
- R6: Suppose the last beat of a triangle is accepted at clock edge T. Then `vis_valid` is high for one cycle, set at edge T+1, and `vis_idx` equals that beat's `pix_idx`.
- R7: A last beat with `pix_void` = 1 carries no pixel. It writes nothing. A triangle made only of such a beat is reported invisible.
- R8: Consecutive pixels at the same coordinate are each compared against the depth left by the pixel before them, even when they arrive on back-to-back cycles.
- R9: The scan-out port returns the depth and triangle number stored at address (`sc_x`, `sc_y`) one cycle after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_go | input | 1 | Start a clear sweep |
| clr_busy | output | 1 | Clear sweep in progress |
| pix_valid | input | 1 | Pixel beat valid |
| pix_ready | output | 1 | Pixel beat accepted when high with valid |
| pix_x | input | CW | Pixel column |
| pix_y | input | CW | Pixel row |
| pix_z | input | DW | Pixel depth, smaller is nearer |
| pix_idx | input | IW | Triangle number |
| pix_last | input | 1 | Final beat of the triangle |
| pix_void | input | 1 | Beat carries no pixel (empty triangle) |
| vis_valid | output | 1 | Verdict pulse |
| vis_idx | output | IW | Triangle number of the verdict |
| vis_hit | output | 1 | 1 = visible, 0 = hidden |
| sc_x | input | CW | Scan-out column |
| sc_y | input | CW | Scan-out row |
| sc_depth | output | DW | Stored depth at scan-out address |
| sc_idx | output | IW | Stored triangle number at scan-out address |

## Verification
The hardest case to reach is a read-after-write hazard. It occurs when two beats hit the same coordinate on adjacent cycles: the second beat's buffer read was issued before the first beat's write landed. To reach it, the stimulus sends back-to-back beats at one location in two forms. In the first, both beats belong to one triangle, and the stored depth after the pair is checked. In the second, each beat is its own single-pixel triangle, and the second triangle's verdict exposes which depth it was compared against.

// File: rtl/zt_pkg.sv
package zt_pkg;
  parameter int ZT_COORD_W = 4;
  parameter int ZT_DEPTH_W = 16;
  parameter int ZT_IDX_W   = 12;
endpackage

// File: rtl/zt_entry_mem.sv
module zt_entry_mem #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdepth,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_depth,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_depth,
  output logic [IW-1:0] rb_idx
);
  localparam int NENT = 1 << AW;
  localparam int EW   = DW + IW;

  logic [EW-1:0] ent_q [NENT];

  // one word per location: depth in the upper bits, triangle number below
  always_ff @(posedge clk) begin
    if (we) ent_q[waddr] <= {wdepth, widx};
    ra_depth <= ent_q[ra_addr][EW-1 -: DW];
    {rb_depth, rb_idx} <= ent_q[rb_addr];
  end
endmodule

// File: rtl/zt_clear_seq.sv
module zt_clear_seq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] addr
);
  logic          busy_q, busy_d;
  logic [AW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == {AW{1'b1}}) busy_d = 1'b0;
    end else if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign we   = busy_q;
  assign addr = cnt_q;
endmodule

// File: rtl/zt_vis_track.sv
module zt_vis_track #(
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          last,
  input  logic          hit_in,
  input  logic [IW-1:0] idx_in,
  output logic          vld,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic          acc_q, acc_d;
  logic          vld_q, vld_d;
  logic          hit_q, hit_d;
  logic [IW-1:0] idx_q;
  logic          done;

  assign done = step & last;

  always_comb begin
    acc_d = acc_q;
    if (step) acc_d = last ? 1'b0 : (acc_q | hit_in);
    vld_d = done;
    hit_d = acc_q | hit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      vld_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      vld_q <= vld_d;
      if (done) hit_q <= hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (done) idx_q <= idx_in;
  end

  assign vld = vld_q;
  assign hit = hit_q;
  assign idx = idx_q;
endmodule

// File: rtl/zidx_depth_test.sv
module zidx_depth_test #(
  parameter int CW = zt_pkg::ZT_COORD_W,
  parameter int DW = zt_pkg::ZT_DEPTH_W,
  parameter int IW = zt_pkg::ZT_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_go,
  output logic          clr_busy,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [DW-1:0] pix_z,
  input  logic [IW-1:0] pix_idx,
  input  logic          pix_last,
  input  logic          pix_void,
  output logic          vis_valid,
  output logic [IW-1:0] vis_idx,
  output logic          vis_hit,
  input  logic [CW-1:0] sc_x,
  input  logic [CW-1:0] sc_y,
  output logic [DW-1:0] sc_depth,
  output logic [IW-1:0] sc_idx
);
  localparam int AW = 2 * CW;

  logic          accept;
  logic [AW-1:0] in_addr;
  logic          s1_v, s1_last, s1_void, s1_fwd;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] s1_z, s1_fwd_z, rd_z, eff_z;
  logic [IW-1:0] s1_idx;
  logic          px_we, clr_we, mem_we;
  logic [AW-1:0] clr_addr, mem_addr;
  logic [DW-1:0] mem_depth;
  logic [IW-1:0] mem_idx;
  logic          fwd_d;

  assign pix_ready = ~clr_busy & ~clr_go;
  assign accept    = pix_valid & pix_ready;
  assign in_addr   = {pix_y, pix_x};

  // stage 2: compare against the read data, or against the depth just written
  assign eff_z = s1_fwd ? s1_fwd_z : rd_z;
  assign px_we = s1_v & ~s1_void & (s1_z < eff_z);
  assign fwd_d = px_we & (s1_addr == in_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_addr  <= in_addr;
      s1_z     <= pix_z;
      s1_idx   <= pix_idx;
      s1_last  <= pix_last;
      s1_void  <= pix_void;
      s1_fwd   <= fwd_d;
      s1_fwd_z <= s1_z;
    end
  end

  zt_clear_seq #(.AW(AW)) u_clr (
    .clk(clk), .rst_n(rst_n), .go(clr_go),
    .busy(clr_busy), .we(clr_we), .addr(clr_addr)
  );

  assign mem_we    = clr_we | px_we;
  assign mem_addr  = clr_we ? clr_addr : s1_addr;
  assign mem_depth = clr_we ? {DW{1'b1}} : s1_z;
  assign mem_idx   = clr_we ? {IW{1'b1}} : s1_idx;

  zt_entry_mem #(.AW(AW), .DW(DW), .IW(IW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdepth(mem_depth), .widx(mem_idx),
    .ra_addr(in_addr), .ra_depth(rd_z),
    .rb_addr({sc_y, sc_x}), .rb_depth(sc_depth), .rb_idx(sc_idx)
  );

  zt_vis_track #(.IW(IW)) u_vis (
    .clk(clk), .rst_n(rst_n), .step(s1_v), .last(s1_last),
    .hit_in(px_we), .idx_in(s1_idx),
    .vld(vis_valid), .hit(vis_hit), .idx(vis_idx)
  );
endmodule

// File: rtl/zt_checks.sv
module zt_checks #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic          pix_last,
  input logic          clr_go,
  input logic          clr_busy,
  input logic          vis_valid,
  input logic          px_we,
  input logic          clr_we,
  input logic [DW-1:0] wr_depth
);
  p_no_accept_in_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !pix_ready);

  p_clear_needs_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_busy) |-> $past(clr_go));

  p_single_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({px_we, clr_we}));

  p_far_never_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    px_we |-> (wr_depth != {DW{1'b1}}));

  p_verdict_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vis_valid |-> $past(pix_valid && pix_ready && pix_last, 2));
endmodule

bind zidx_depth_test zt_checks #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_last(pix_last), .clr_go(clr_go), .clr_busy(clr_busy),
  .vis_valid(vis_valid), .px_we(px_we), .clr_we(clr_we), .wr_depth(s1_z)
);

// File: tb/zidx_depth_test_tb.sv
`timescale 1ns/1ps
module zidx_depth_test_tb;
  localparam int CW = 4, DW = 16, IW = 12;

  logic clk, rst_n, clr_go, clr_busy;
  logic pix_valid, pix_ready, pix_last, pix_void;
  logic [CW-1:0] pix_x, pix_y, sc_x, sc_y;
  logic [DW-1:0] pix_z, sc_depth;
  logic [IW-1:0] pix_idx, vis_idx, sc_idx;
  logic vis_valid, vis_hit;

  int n_chk = 0, n_fail = 0, vcnt = 0;
  logic [IW-1:0] vlog_idx [32];
  logic          vlog_hit [32];

  zidx_depth_test #(.CW(CW), .DW(DW), .IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_go(clr_go), .clr_busy(clr_busy),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
    .pix_z(pix_z), .pix_idx(pix_idx), .pix_last(pix_last), .pix_void(pix_void),
    .vis_valid(vis_valid), .vis_idx(vis_idx), .vis_hit(vis_hit),
    .sc_x(sc_x), .sc_y(sc_y), .sc_depth(sc_depth), .sc_idx(sc_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && vis_valid) begin
      if (vcnt < 32) begin
        vlog_idx[vcnt] = vis_idx;
        vlog_hit[vcnt] = vis_hit;
      end
      vcnt = vcnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic beat(input int x, input int y, input int z, input int idx,
                      input bit last, input bit vd);
    pix_valid = 1'b1;
    pix_x = x[CW-1:0]; pix_y = y[CW-1:0]; pix_z = z[DW-1:0];
    pix_idx = idx[IW-1:0]; pix_last = last; pix_void = vd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    pix_valid = 1'b0; pix_last = 1'b0; pix_void = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_chk(input int x, input int y, input int ez, input int ei, input string tag);
    sc_x = x[CW-1:0]; sc_y = y[CW-1:0];
    @(negedge clk);
    chk({tag, " depth"}, 32'(sc_depth), 32'(ez));
    chk({tag, " index"}, 32'(sc_idx), 32'(ei));
  endtask

  task automatic verdict_chk(input int k, input int idx, input bit hit, input string tag);
    chk({tag, " verdict index"}, 32'(vlog_idx[k]), 32'(idx));
    chk({tag, " verdict visible"}, 32'(vlog_hit[k]), 32'(hit));
  endtask

  task automatic t_reset();
    chk("R1 pix_ready", 32'(pix_ready), 1);
    chk("R1 vis_valid", 32'(vis_valid), 0);
    chk("R1 clr_busy", 32'(clr_busy), 0);
  endtask

  task automatic t_clear();
    int busy_cycles = 0;
    clr_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr_go = 1'b0;
    chk("R2 ready low while clearing", 32'(pix_ready), 0);
    while (clr_busy && busy_cycles < 1000) begin
      busy_cycles++;
      @(negedge clk);
    end
    chk("R2 clear length", 32'(busy_cycles), 256);
    chk("R2 ready after clear", 32'(pix_ready), 1);
    rd_chk(0, 0, 16'hFFFF, 12'hFFF, "R2 entry 0,0");
    rd_chk(15, 15, 16'hFFFF, 12'hFFF, "R2 entry 15,15");
    rd_chk(1, 1, 16'hFFFF, 12'hFFF, "R2 entry 1,1");
  endtask

  task automatic t_single();
    int base = vcnt;
    beat(1, 1, 100, 5, 0, 0);
    beat(2, 1, 200, 5, 1, 0);
    idle();
    chk("R6 no verdict one edge after last", 32'(vis_valid), 0);
    @(negedge clk);
    chk("R6 verdict pulse", 32'(vis_valid), 1);
    chk("R6 verdict index", 32'(vis_idx), 5);
    chk("R4 verdict visible", 32'(vis_hit), 1);
    @(negedge clk);
    chk("R6 pulse ends", 32'(vis_valid), 0);
    chk("R6 verdict count", 32'(vcnt - base), 1);
    rd_chk(1, 1, 100, 5, "R3 R9 pass written");
  endtask

  task automatic t_occluded();
    int base = vcnt;
    beat(1, 1, 150, 6, 0, 0);
    beat(2, 1, 200, 6, 1, 0);
    idle(); settle();
    chk("R5 one verdict", 32'(vcnt - base), 1);
    verdict_chk(base, 6, 0, "R5 hidden");
    rd_chk(1, 1, 100, 5, "R3 greater keeps entry");
    rd_chk(2, 1, 200, 5, "R3 equal keeps entry");
  endtask

  task automatic t_partial();
    int base = vcnt;
    beat(1, 1, 150, 7, 0, 0);
    beat(2, 1, 199, 7, 1, 0);
    idle(); settle();
    verdict_chk(base, 7, 1, "R4 partly visible");
    rd_chk(2, 1, 199, 7, "R3 depth and index together");
  endtask

  task automatic t_fwd();
    int base = vcnt;
    beat(5, 5, 50, 8, 0, 0);
    beat(5, 5, 60, 8, 1, 0);
    idle(); settle();
    rd_chk(5, 5, 50, 8, "R8 same triangle back-to-back");
    base = vcnt;
    beat(5, 5, 40, 9, 1, 0);
    beat(5, 5, 45, 10, 1, 0);
    idle(); settle();
    chk("R8 two verdicts", 32'(vcnt - base), 2);
    verdict_chk(base, 9, 1, "R8 first nearer");
    verdict_chk(base + 1, 10, 0, "R8 second behind forwarded");
    rd_chk(5, 5, 40, 9, "R8 final entry");
  endtask

  task automatic t_empty();
    int base = vcnt;
    beat(5, 5, 0, 11, 1, 1);
    idle(); settle();
    chk("R7 one verdict", 32'(vcnt - base), 1);
    verdict_chk(base, 11, 0, "R7 empty triangle");
    rd_chk(5, 5, 40, 9, "R7 void beat writes nothing");
  endtask

  task automatic t_far();
    int base = vcnt;
    beat(0, 0, 16'hFFFF, 12, 1, 0);
    idle(); settle();
    verdict_chk(base, 12, 0, "R3 max depth never passes");
    rd_chk(0, 0, 16'hFFFF, 12'hFFF, "R3 cleared entry kept");
  endtask

  initial begin
    rst_n = 1'b0; clr_go = 1'b0; idle();
    pix_x = '0; pix_y = '0; pix_z = '0; pix_idx = '0; sc_x = '0; sc_y = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clear();
    t_single();
    t_occluded();
    t_partial();
    t_fwd();
    t_empty();
    t_clear();
    t_far();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule